// File: doc/BRIEF.md
# Three-Operand NaN Propagation Unit

This unit sits ahead of a fused multiply-add datapath and looks at its three source operands before the arithmetic runs. Each operand is in an 82-bit register format. The sign is the top bit. Below it is a 17-bit exponent, and below that a 64-bit significand whose bit 63 is an explicit integer bit. The unit decides for each operand whether it is a NaN, and whether that NaN is signaling or quiet.

When one or more operands are NaNs, the unit picks one of them by a fixed priority and returns it in quiet form. It also raises a bypass flag, so the arithmetic result is thrown away in favour of the propagated NaN. A signaling NaN on any input raises an invalid flag. A mode input marks non-arithmetic operations, and for those the invalid flag is held low.

All outputs are registered, with a one-cycle latency that follows a valid strobe. Rounding, the arithmetic itself and exception trap delivery belong to other blocks.

Top module: `nanprop_unit`

## Requirements
- R1: An operand is a NaN exactly when its exponent field (bits 80:64) is all ones (0x1FFFF) and its fraction bits 62:0 are not all zero. The integer bit 63 and the sign bit 81 play no part. An all-ones exponent with zero fraction (infinity) is not a NaN.
- R2: A NaN with bit 62 equal to 1 is quiet. A NaN with bit 62 equal to 0 is signaling.
- R3: When several operands are NaNs, the result comes from `src0` first, then `src1`, then `src2`.
- R4: The propagated result equals the chosen NaN operand with bit 62 forced to 1. Its sign, exponent, integer bit and the other payload bits are unchanged.
- R5: `invalid` rises when any of the three operands is a signaling NaN, even when the operand that is chosen is a quiet NaN.
- R6: While `nonarith` is 1, `invalid` stays 0. `nan_bypass` and `result` behave as they do when `nonarith` is 0.
- R7: When no operand is a NaN, `nan_bypass`, `invalid` and `result` are all 0.
- R8: `valid_out` equals `valid_in` from the previous clock edge. Results appear one cycle after the operands are presented. In a cycle where `valid_out` is 0, `nan_bypass`, `invalid` and `result` are 0.
- R9: A synchronous active-high `rst` clears `valid_out`, `nan_bypass`, `invalid` and `result` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands are present this cycle |
| nonarith | input | 1 | Non-arithmetic operation; suppresses `invalid` |
| src0 | input | 82 | Highest-priority operand |
| src1 | input | 82 | Middle-priority operand |
| src2 | input | 82 | Lowest-priority operand |
| valid_out | output | 1 | Registered results are valid |
| nan_bypass | output | 1 | A NaN was found; discard the arithmetic result |
| invalid | output | 1 | A signaling NaN was found (arithmetic operations only) |
| result | output | 82 | Quieted NaN to forward, zero otherwise |

## Verification
The assertions check a set of rules on every cycle:
- the one-cycle valid relation;
- idle outputs being zero;
- `invalid` never appearing without `nan_bypass`;
- every forwarded result being a quiet NaN;
- the non-arithmetic mode suppressing `invalid`;
- a NaN on `src0` always winning.

Two things can be shown only by the bench's sweep of every class combination across the three operands. The first is the full priority order among the lower operands. The second is that a signaling NaN hidden behind a higher-priority quiet NaN still raises `invalid`. The sweep also covers the exact payload each combination yields.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;

   // Operand class produced by the per-operand classifier
   typedef enum logic [1:0] {
      CLS_NUM  = 2'd0,
      CLS_QNAN = 2'd1,
      CLS_SNAN = 2'd2
   } nan_cls_e;

   function automatic logic cls_is_nan(nan_cls_e c);
      return (c == CLS_QNAN) || (c == CLS_SNAN);
   endfunction

   function automatic logic cls_is_snan(nan_cls_e c);
      return c == CLS_SNAN;
   endfunction

endpackage

// File: rtl/nanprop_classify.sv
module nanprop_classify
   import nanprop_pkg::*;
#(
   parameter int EXP_W        = 17,
   parameter int SIG_W        = 64,
   parameter bit EXPLICIT_INT = 1'b1
) (
   input  logic [EXP_W+SIG_W:0] opnd,
   output nan_cls_e             cls
);
   // Quiet-select bit: top fraction bit, below the integer bit when it is stored
   localparam int QBIT = EXPLICIT_INT ? SIG_W - 2 : SIG_W - 1;

   logic [EXP_W-1:0] expo;
   logic [QBIT:0]    frac;
   logic             is_nan;

   assign expo = opnd[SIG_W +: EXP_W];

   generate
      if (EXPLICIT_INT) begin : g_explicit
         // integer bit excluded from the fraction test
         assign frac = opnd[SIG_W-2:0];
      end else begin : g_implicit
         assign frac = opnd[SIG_W-1:0];
      end
   endgenerate

   always_comb begin
      is_nan = (&expo) && (|frac);
      if (!is_nan)
         cls = CLS_NUM;
      else if (frac[QBIT])
         cls = CLS_QNAN;
      else
         cls = CLS_SNAN;
   end

endmodule

// File: rtl/nanprop_select.sv
module nanprop_select #(
   parameter int W    = 82,
   parameter int N    = 3,
   parameter int QBIT = 62
) (
   input  logic [N-1:0][W-1:0] opnds,
   input  logic [N-1:0]        is_nan,
   input  logic [N-1:0]        is_snan,
   output logic                any_nan,
   output logic                any_snan,
   output logic [W-1:0]        quieted
);
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
   localparam logic [W-1:0] QMASK = {{(W-1){1'b0}}, 1'b1} << QBIT;

   logic [IDX_W-1:0] pick;

   // Lowest index has the highest priority: scan from the bottom of the
   // priority list so the last match written wins.
   always_comb begin
      pick = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (is_nan[i]) pick = IDX_W'(i);
      end
   end

   assign any_nan  = |is_nan;
   assign any_snan = |is_snan;
   assign quieted  = any_nan ? (opnds[pick] | QMASK) : '0;

endmodule

// File: rtl/nanprop_unit.sv
module nanprop_unit
   import nanprop_pkg::*;
#(
   parameter int EXP_W        = 17,
   parameter int SIG_W        = 64,
   parameter bit EXPLICIT_INT = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   valid_in,
   input  logic                   nonarith,
   input  logic [EXP_W+SIG_W:0]   src0,
   input  logic [EXP_W+SIG_W:0]   src1,
   input  logic [EXP_W+SIG_W:0]   src2,
   output logic                   valid_out,
   output logic                   nan_bypass,
   output logic                   invalid,
   output logic [EXP_W+SIG_W:0]   result
);
   localparam int W      = 1 + EXP_W + SIG_W;
   localparam int N_OPND = 3;
   localparam int QBIT   = EXPLICIT_INT ? SIG_W - 2 : SIG_W - 1;

   generate
      if (EXP_W < 2) begin : g_bad_exp
         $error("nanprop_unit: EXP_W must be at least 2");
      end
      if (SIG_W < 3) begin : g_bad_sig
         $error("nanprop_unit: SIG_W must be at least 3");
      end
   endgenerate

   logic [N_OPND-1:0][W-1:0] opnds;
   logic [N_OPND-1:0]        nan_v;
   logic [N_OPND-1:0]        snan_v;
   logic                     any_nan;
   logic                     any_snan;
   logic [W-1:0]             quieted;

   assign opnds = {src2, src1, src0};

   generate
      for (genvar g = 0; g < N_OPND; g++) begin : g_cls
         nan_cls_e c;
         nanprop_classify #(
            .EXP_W       (EXP_W),
            .SIG_W       (SIG_W),
            .EXPLICIT_INT(EXPLICIT_INT)
         ) u_cls (
            .opnd(opnds[g]),
            .cls (c)
         );
         assign nan_v[g]  = cls_is_nan(c);
         assign snan_v[g] = cls_is_snan(c);
      end
   endgenerate

   nanprop_select #(
      .W   (W),
      .N   (N_OPND),
      .QBIT(QBIT)
   ) u_sel (
      .opnds   (opnds),
      .is_nan  (nan_v),
      .is_snan (snan_v),
      .any_nan (any_nan),
      .any_snan(any_snan),
      .quieted (quieted)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_out  <= 1'b0;
         nan_bypass <= 1'b0;
         invalid    <= 1'b0;
         result     <= '0;
      end else begin
         valid_out  <= valid_in;
         nan_bypass <= valid_in && any_nan;
         invalid    <= valid_in && any_snan && !nonarith;
         result     <= valid_in ? quieted : '0;
      end
   end

endmodule

// File: rtl/nanprop_checker.sv
module nanprop_checker #(
   parameter int EXP_W        = 17,
   parameter int SIG_W        = 64,
   parameter bit EXPLICIT_INT = 1'b1
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 valid_in,
   input logic                 nonarith,
   input logic [EXP_W+SIG_W:0] src0,
   input logic                 valid_out,
   input logic                 nan_bypass,
   input logic                 invalid,
   input logic [EXP_W+SIG_W:0] result
);
   localparam int W    = 1 + EXP_W + SIG_W;
   localparam int QBIT = EXPLICIT_INT ? SIG_W - 2 : SIG_W - 1;
   localparam logic [W-1:0] QMASK = {{(W-1){1'b0}}, 1'b1} << QBIT;

   logic src0_nan;
   assign src0_nan = (&src0[SIG_W +: EXP_W]) && (|src0[QBIT:0]);

   assert_latency_hi_R8: assert property (@(posedge clk) disable iff (rst)
      valid_in |=> valid_out);
   assert_latency_lo_R8: assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> !valid_out);
   assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
      !valid_out |-> (!nan_bypass && !invalid && result == '0));
   assert_invalid_has_nan_R5: assert property (@(posedge clk) disable iff (rst)
      invalid |-> nan_bypass);
   assert_nonarith_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      (valid_in && nonarith) |=> !invalid);
   assert_result_quiet_R4: assert property (@(posedge clk) disable iff (rst)
      nan_bypass |-> (result[QBIT] && (&result[SIG_W +: EXP_W])));
   assert_clean_result_R7: assert property (@(posedge clk) disable iff (rst)
      !nan_bypass |-> (result == '0 && !invalid));
   assert_src0_wins_R3: assert property (@(posedge clk) disable iff (rst)
      (valid_in && src0_nan) |=> (nan_bypass && result == ($past(src0) | QMASK)));
   assert_reset_clears_R9: assert property (@(posedge clk)
      rst |=> (!valid_out && !nan_bypass && !invalid && result == '0));

endmodule

bind nanprop_unit nanprop_checker #(
   .EXP_W       (EXP_W),
   .SIG_W       (SIG_W),
   .EXPLICIT_INT(EXPLICIT_INT)
) u_nanprop_checker (
   .clk       (clk),
   .rst       (rst),
   .valid_in  (valid_in),
   .nonarith  (nonarith),
   .src0      (src0),
   .valid_out (valid_out),
   .nan_bypass(nan_bypass),
   .invalid   (invalid),
   .result    (result)
);

// File: tb/nanprop_unit_bench.sv
`timescale 1ns/1ps
module nanprop_unit_bench;
   localparam int W = 82;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         valid_in = 1'b0;
   logic         nonarith = 1'b0;
   logic [W-1:0] src0 = '0, src1 = '0, src2 = '0;
   logic         valid_out, nan_bypass, invalid;
   logic [W-1:0] result;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;  // 250 MHz

   nanprop_unit u_nanprop_unit (
      .clk(clk), .rst(rst), .valid_in(valid_in), .nonarith(nonarith),
      .src0(src0), .src1(src1), .src2(src2),
      .valid_out(valid_out), .nan_bypass(nan_bypass), .invalid(invalid),
      .result(result)
   );

   // class: 0 number, 1 infinity, 2 quiet NaN, 3 signaling NaN
   function automatic logic [W-1:0] make_op(int cls, int seed);
      logic        s;
      logic        ib;
      logic [61:0] pay;
      s   = seed[0];
      ib  = seed[1];
      pay = 62'(seed) * 62'h0123_4567_89AB;
      case (cls)
         0: return {s, 17'h0FFFF ^ 17'(seed), 1'b1, 63'(seed) * 63'h35};
         1: return {s, 17'h1FFFF, ib, 63'd0};
         2: return {s, 17'h1FFFF, ib, 1'b1, pay};
         default: return {s, 17'h1FFFF, ib, 1'b0, (pay == '0) ? 62'd1 : pay};
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic present(input bit v, input bit na, input logic [W-1:0] a,
                          input logic [W-1:0] b, input logic [W-1:0] c);
      @(negedge clk);
      valid_in = v; nonarith = na; src0 = a; src1 = b; src2 = c;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(4 * 100000);
      if (!finished) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] ops [3];
      int           cls [3];
      logic [W-1:0] exp_res;
      bit           exp_byp, exp_inv, found;

      repeat (3) @(posedge clk);
      #1;
      // R9: reset state
      check(!valid_out && !nan_bypass && !invalid && result == '0, "R9 reset",
            {valid_out, nan_bypass, invalid}, '0);
      @(negedge clk);
      rst = 1'b0;

      // R1 R2 R3 R4 R5 R6 R7 R8: every class combination, both modes
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++)
               for (int na = 0; na < 2; na++) begin
                  cls[0] = a; cls[1] = b; cls[2] = c;
                  for (int k = 0; k < 3; k++)
                     ops[k] = make_op(cls[k], a * 97 + b * 31 + c * 7 + na * 3 + k);
                  found = 1'b0; exp_res = '0; exp_inv = 1'b0;
                  for (int k = 0; k < 3; k++) begin
                     if (cls[k] == 3) exp_inv = 1'b1;
                     if (!found && cls[k] >= 2) begin
                        found   = 1'b1;
                        exp_res = ops[k] | (82'd1 << 62);
                     end
                  end
                  exp_byp = found;
                  if (na == 1) exp_inv = 1'b0;
                  present(1'b1, na[0], ops[0], ops[1], ops[2]);
                  check(valid_out == 1'b1, "R8 valid latency", W'(valid_out), W'(1));
                  check(nan_bypass == exp_byp, "R1 R7 nan_bypass", W'(nan_bypass), W'(exp_byp));
                  check(invalid == exp_inv, "R2 R5 R6 invalid", W'(invalid), W'(exp_inv));
                  check(result == exp_res, "R3 R4 R7 result", result, exp_res);
               end

      // R1: signaling NaN with only the lowest fraction bit set, integer bit 0
      present(1'b1, 1'b0, {1'b1, 17'h1FFFF, 64'd1}, '0, '0);
      check(nan_bypass && invalid && result == {1'b1, 17'h1FFFF, 2'b01, 62'd1},
            "R1 minimal snan", result, {1'b1, 17'h1FFFF, 2'b01, 62'd1});
      // R1: exponent one below all ones is a number
      present(1'b1, 1'b0, {1'b0, 17'h1FFFE, 64'h7FFF_FFFF_FFFF_FFFF}, '0, '0);
      check(!nan_bypass && result == '0, "R1 near-max exponent", result, '0);

      // R8: valid_in low with NaNs on the inputs gives zero outputs
      present(1'b0, 1'b0, make_op(3, 5), make_op(2, 6), make_op(3, 7));
      check(!valid_out && !nan_bypass && !invalid && result == '0, "R8 idle",
            result, '0);

      // R9: mid-run reset
      present(1'b1, 1'b0, make_op(3, 9), '0, '0);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #1;
      check(!valid_out && !nan_bypass && !invalid && result == '0, "R9 mid-run reset",
            result, '0);
      @(negedge clk);
      rst = 1'b0;
      valid_in = 1'b0;
      @(posedge clk);
      #1;

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule